// File: doc/BRIEF.md
# Per-Module Standby Clock Gate Controller

This block holds a three-bit stop register. Each bit turns off the clock of one on-chip peripheral: a timer, a real-time clock and a serial port. When a peripheral is stopped, the block also applies a side effect that belongs to that peripheral alone. The timer gets a one-cycle pulse that initializes its registers, and its pins hold their last levels. The real-time clock's register interface is locked out, while its counter clock is left running. The serial port's pins are forced to their reset state.

The clock enables are updated on the falling edge of the clock. A downstream clock-gating cell therefore sees a new enable only while the clock is low. Accesses to the real-time clock pass through this block. While that peripheral is locked, the block filters each access and records it in a sticky error flag, which software clears.

Top module: `modstby_ctrl`

## Requirements
- R1: After reset the stop register reads 000, all three clock enables are 1, and tmr_reg_init, tmr_pin_hold, ser_pin_rst, rtc_lock and rtc_err are all 0.
- R2: A write on cfg_wr loads cfg_wdata into the stop register at the next rising edge, and cfg_rdata returns the stored value from then on. Bit 2 is the timer, bit 1 the real-time clock and bit 0 the serial port; 1 means stopped.
- R3: Each clock enable equals the inverse of its stop bit. After a rising edge that changes a stop bit, the enable changes at the following falling edge and not before.
- R4: tmr_reg_init is high for exactly one cycle after a write that takes bit 2 from 0 to 1. A write that leaves bit 2 at 1, or clears it, gives no pulse.
- R5: tmr_pin_hold is high exactly while bit 2 of the stop register is 1.
- R6: ser_pin_rst is high exactly while bit 0 of the stop register is 1.
- R7: While bit 1 is 1, rtc_lock is high, rtc_req_o and rtc_we_o stay 0, and rtc_rdata_o reads zero, whatever the requester drives.
- R8: A request on rtc_req_i while bit 1 is 1 sets rtc_err at the next rising edge. The flag stays set until rtc_err_clr is sampled high with no new blocked request in the same cycle; a blocked request wins over a clear.
- R9: While bit 1 is 0, rtc_req_i, rtc_we_i and rtc_rdata_i pass unchanged to rtc_req_o, rtc_we_o and rtc_rdata_o, and such accesses never set rtc_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Stop register write strobe |
| cfg_wdata | input | 3 | Stop register write data |
| cfg_rdata | output | 3 | Stop register contents |
| rtc_req_i | input | 1 | Access request to the real-time clock |
| rtc_we_i | input | 1 | Write qualifier of that request |
| rtc_rdata_i | input | DW | Read data from the real-time clock |
| rtc_err_clr | input | 1 | Clears the blocked-access flag |
| rtc_req_o | output | 1 | Filtered request to the real-time clock |
| rtc_we_o | output | 1 | Filtered write qualifier |
| rtc_rdata_o | output | DW | Filtered read data to the requester |
| rtc_err | output | 1 | Sticky blocked-access flag |
| tmr_clk_en | output | 1 | Timer clock enable |
| rtc_clk_en | output | 1 | Real-time clock interface clock enable |
| ser_clk_en | output | 1 | Serial port clock enable |
| tmr_reg_init | output | 1 | One-cycle timer register initialize pulse |
| tmr_pin_hold | output | 1 | Timer pin level hold |
| ser_pin_rst | output | 1 | Serial pin reset-state force |
| rtc_lock | output | 1 | Real-time clock access lockout |

## Verification
The hardest case to reach is the half cycle between the rising edge that stores a new stop value and the falling edge that moves the enable. In that window, tmr_reg_init and tmr_pin_hold already show the new state while the enable still shows the old one. The stimulus writes on a rising edge and samples twice: once two nanoseconds later, and again after the falling edge. The second case is a blocked access and an error clear in the same cycle, to check that the block gives the set priority. The stimulus drives both inputs in one cycle while the real-time clock is stopped.

// File: rtl/modstby_pkg.sv
package modstby_pkg;
    localparam int MS_NMOD = 3;
    localparam int MS_TMR  = 2;
    localparam int MS_RTC  = 1;
    localparam int MS_SER  = 0;

    typedef struct packed {
        logic [MS_NMOD-1:0] stop;
        logic               tmr_init;
        logic               rtc_err;
    } ms_ctl_t;
endpackage

// File: rtl/modstby_reg.sv
module modstby_reg
    import modstby_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [MS_NMOD-1:0] wdata,
    input  logic               rtc_blocked,
    input  logic               err_clr,
    output logic [MS_NMOD-1:0] stop,
    output logic               tmr_init,
    output logic               rtc_err
);
    ms_ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr) begin
            ctl_d.stop = wdata;
        end
        // pulse only on a rising stop bit of the timer
        ctl_d.tmr_init = ctl_d.stop[MS_TMR] & ~ctl_q.stop[MS_TMR];
        // a new blocked access outranks a clear
        ctl_d.rtc_err  = rtc_blocked | (ctl_q.rtc_err & ~err_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign stop     = ctl_q.stop;
    assign tmr_init = ctl_q.tmr_init;
    assign rtc_err  = ctl_q.rtc_err;
endmodule

// File: rtl/modstby_gate.sv
module modstby_gate #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] stop,
    output logic [N-1:0] clk_en
);
    for (genvar i = 0; i < N; i++) begin : g_en
        logic en_d, en_q;

        always_comb begin
            en_d = ~stop[i];
        end

        // launched on the falling edge so the enable settles in the low phase
        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q <= 1'b1;
            end else begin
                en_q <= en_d;
            end
        end

        assign clk_en[i] = en_q;
    end
endmodule

// File: rtl/modstby_rtc_guard.sv
module modstby_rtc_guard #(
    parameter int DW = 8
) (
    input  logic          lock,
    input  logic          req_i,
    input  logic          we_i,
    input  logic [DW-1:0] rdata_i,
    output logic          req_o,
    output logic          we_o,
    output logic [DW-1:0] rdata_o,
    output logic          blocked
);
    always_comb begin
        req_o   = req_i & ~lock;
        we_o    = we_i & ~lock;
        rdata_o = lock ? '0 : rdata_i;
        blocked = req_i & lock;
    end
endmodule

// File: rtl/modstby_ctrl.sv
module modstby_ctrl
    import modstby_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [2:0]    cfg_wdata,
    output logic [2:0]    cfg_rdata,
    input  logic          rtc_req_i,
    input  logic          rtc_we_i,
    input  logic [DW-1:0] rtc_rdata_i,
    input  logic          rtc_err_clr,
    output logic          rtc_req_o,
    output logic          rtc_we_o,
    output logic [DW-1:0] rtc_rdata_o,
    output logic          rtc_err,
    output logic          tmr_clk_en,
    output logic          rtc_clk_en,
    output logic          ser_clk_en,
    output logic          tmr_reg_init,
    output logic          tmr_pin_hold,
    output logic          ser_pin_rst,
    output logic          rtc_lock
);
    logic [MS_NMOD-1:0] stop;
    logic [MS_NMOD-1:0] en;
    logic               blocked;

    modstby_reg u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (cfg_wr),
        .wdata       (cfg_wdata),
        .rtc_blocked (blocked),
        .err_clr     (rtc_err_clr),
        .stop        (stop),
        .tmr_init    (tmr_reg_init),
        .rtc_err     (rtc_err)
    );

    modstby_gate #(.N(MS_NMOD)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .stop   (stop),
        .clk_en (en)
    );

    modstby_rtc_guard #(.DW(DW)) u_guard (
        .lock    (stop[MS_RTC]),
        .req_i   (rtc_req_i),
        .we_i    (rtc_we_i),
        .rdata_i (rtc_rdata_i),
        .req_o   (rtc_req_o),
        .we_o    (rtc_we_o),
        .rdata_o (rtc_rdata_o),
        .blocked (blocked)
    );

    assign cfg_rdata    = stop;
    assign tmr_clk_en   = en[MS_TMR];
    assign rtc_clk_en   = en[MS_RTC];
    assign ser_clk_en   = en[MS_SER];
    assign tmr_pin_hold = stop[MS_TMR];
    assign ser_pin_rst  = stop[MS_SER];
    assign rtc_lock     = stop[MS_RTC];
endmodule

// File: rtl/modstby_chk.sv
module modstby_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_wr,
    input logic [2:0]    cfg_wdata,
    input logic [2:0]    cfg_rdata,
    input logic          rtc_req_i,
    input logic          rtc_we_i,
    input logic [DW-1:0] rtc_rdata_i,
    input logic          rtc_req_o,
    input logic          rtc_we_o,
    input logic [DW-1:0] rtc_rdata_o,
    input logic          rtc_err,
    input logic          tmr_clk_en,
    input logic          rtc_clk_en,
    input logic          ser_clk_en,
    input logic          tmr_reg_init,
    input logic          tmr_pin_hold,
    input logic          ser_pin_rst,
    input logic          rtc_lock
);
    // R2
    wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> cfg_rdata == $past(cfg_wdata));
    // R3
    tmr_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_clk_en == !tmr_pin_hold);
    // R3
    rtc_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_clk_en == !rtc_lock);
    // R6
    ser_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk_en == !ser_pin_rst);
    // R4
    tinit_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_reg_init |-> (tmr_pin_hold && !$past(tmr_pin_hold)));
    // R4
    tinit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_reg_init |=> !tmr_reg_init);
    // R7
    rtc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_lock |-> (!rtc_req_o && !rtc_we_o && rtc_rdata_o == '0));
    // R8
    rtc_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rtc_lock && rtc_req_i) |=> rtc_err);
    // R9
    rtc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rtc_lock |-> (rtc_req_o == rtc_req_i && rtc_we_o == rtc_we_i
                       && rtc_rdata_o == rtc_rdata_i));
endmodule

bind modstby_ctrl modstby_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_modstby_ctrl.sv
module tb_modstby_ctrl;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_wdata = '0;
    logic [2:0]    cfg_rdata;
    logic          rtc_req_i = 1'b0;
    logic          rtc_we_i = 1'b0;
    logic [DW-1:0] rtc_rdata_i = '0;
    logic          rtc_err_clr = 1'b0;
    logic          rtc_req_o, rtc_we_o, rtc_err;
    logic [DW-1:0] rtc_rdata_o;
    logic          tmr_clk_en, rtc_clk_en, ser_clk_en;
    logic          tmr_reg_init, tmr_pin_hold, ser_pin_rst, rtc_lock;

    always #4 clk = ~clk;

    modstby_ctrl #(.DW(DW)) dut (.*);

    typedef struct {
        string       tag;
        logic [21:0] v;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    logic [2:0] m_stop = '0;
    logic       m_err  = 1'b0;

    function automatic logic [21:0] actual();
        return {cfg_rdata, tmr_clk_en, rtc_clk_en, ser_clk_en, tmr_reg_init,
                tmr_pin_hold, ser_pin_rst, rtc_lock, rtc_err,
                rtc_req_o, rtc_we_o, rtc_rdata_o};
    endfunction

    // driver side: build the expected snapshot from the model
    task automatic expect_now(string tag, logic [2:0] en, logic pulse);
        exp_t it;
        logic lk;
        lk = m_stop[1];
        it.tag = tag;
        it.v = {m_stop, en, pulse, m_stop[2], m_stop[0], lk, m_err,
                rtc_req_i & ~lk, rtc_we_i & ~lk, lk ? 8'h00 : rtc_rdata_i};
        q.push_back(it);
        #0;
    endtask

    // monitor side
    initial begin
        forever begin
            exp_t it;
            logic [21:0] a;
            wait (q.size() != 0);
            it = q.pop_front();
            a = actual();
            checks++;
            if (a !== it.v) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, a, it.v);
            end
        end
    end

    // write the stop register: drives at posedge+1, returns at posedge+1 after capture
    task automatic wr_stop(logic [2:0] v, string tag);
        logic [2:0] old;
        logic pulse;
        old = m_stop;
        cfg_wr = 1'b1;
        cfg_wdata = v;
        @(posedge clk);
        #1;
        cfg_wr = 1'b0;
        m_stop = v;
        pulse = v[2] & ~old[2];
        #1;
        expect_now({tag, " early"}, ~old, pulse);   // enables not yet moved
        #3;
        expect_now({tag, " late"}, ~v, pulse);      // after falling edge
        @(posedge clk);
        #1;
        expect_now({tag, " next"}, ~v, 1'b0);
    endtask

    task automatic rtc_access(logic we, logic [7:0] rd, logic clr, string tag);
        rtc_req_i = 1'b1;
        rtc_we_i = we;
        rtc_rdata_i = rd;
        rtc_err_clr = clr;
        #1;
        expect_now({tag, " comb"}, ~m_stop, 1'b0);
        @(posedge clk);
        #1;
        m_err = m_stop[1] | (m_err & ~clr);
        rtc_req_i = 1'b0;
        rtc_we_i = 1'b0;
        rtc_err_clr = 1'b0;
        #1;
        expect_now({tag, " flag"}, ~m_stop, 1'b0);
    endtask

    task automatic clear_err(string tag);
        rtc_err_clr = 1'b1;
        @(posedge clk);
        #1;
        rtc_err_clr = 1'b0;
        m_err = 1'b0;
        #1;
        expect_now(tag, ~m_stop, 1'b0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #13;
        expect_now("R1 reset held", 3'b111, 1'b0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        expect_now("R1 after reset", 3'b111, 1'b0);

        // R9: pass-through with nothing stopped, no error
        rtc_access(1'b0, 8'hA5, 1'b0, "R9 read pass");
        rtc_access(1'b1, 8'h3C, 1'b0, "R9 write pass");

        // R2 R3 R4 R5: stop timer only
        wr_stop(3'b100, "R4 timer stop");
        // R4: rewrite with bit 2 still 1 gives no pulse
        wr_stop(3'b101, "R4 no repulse R6 serial");
        wr_stop(3'b001, "R5 timer run");
        wr_stop(3'b100, "R4 second rise");

        // R7 R8: lock RTC, blocked access
        wr_stop(3'b010, "R2 rtc stop");
        rtc_access(1'b0, 8'h5A, 1'b0, "R7 blocked read");
        rtc_access(1'b1, 8'hFF, 1'b0, "R7 blocked write");
        clear_err("R8 clear");
        // R8: blocked access wins over a clear in the same cycle
        rtc_access(1'b0, 8'h11, 1'b1, "R8 set beats clear");
        wr_stop(3'b000, "R3 all run");
        // R8: flag stays while unlocked, then R9 access keeps it
        rtc_access(1'b0, 8'h77, 1'b0, "R8 sticky R9");
        clear_err("R8 clear unlocked");
        wr_stop(3'b111, "R2 all stop");
        wr_stop(3'b000, "R3 release");

        #20;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule